// File: doc/BRIEF.md
# Alternating Row Buffer for Character Display

This block feeds a character display one row at a time from two row registers that take turns. One register, the shifting bank, presents its characters to the display. A new-word strobe steps through that row one character at a time. Meanwhile the other register, the loading bank, takes the next row from frame memory. It accepts one word per load pulse. A new-line strobe exchanges the two roles. A new-page strobe puts the sequencing back to its starting state for the next frame.

Words are 16 bits wide inside the block, but only the low 15 bits reach the display. A self-test mode is active whenever a manual test input or a software test request is high. In this mode the display stream is a pattern built from the character counter instead of stored data. The display side returns the word it received on a loopback input. When that word differs from the expected pattern, a sticky error flag is raised. A second flag records load pulses that arrive after the loading row is already full.

Top module: `row_pingpong_buffer`

## Requirements
- R1: After a synchronous active-low reset, both rows hold zero, the bank select is 0, both indices are 0, and `disp_word`, `selftest_err` and `load_ovf` are all 0.
- R2: A `load_pulse` cycle writes `load_word` into the loading bank (the bank that is not selected) at the load index, then increments that index.
- R3: Outside test mode, `disp_word` equals the low 15 bits of the selected bank at the character index. Each `new_word` increments the character index, which saturates at 79.
- R4: `new_line` inverts the bank select and clears the character and load indices. In that cycle, `new_word` and `load_pulse` have no effect.
- R5: `new_page` clears the bank select to 0 and clears both indices. It takes priority over `new_line`, `new_word` and `load_pulse` in the same cycle.
- R6: Test mode is `test_manual` OR `test_soft`. In test mode, bit i of `disp_word` is bit (i mod 7) of the character index.
- R7: In test mode, `selftest_err` is set one cycle after `disp_loopback` differs from the test pattern, and it stays set while test mode lasts. It reads 0 one cycle after test mode ends.
- R8: A `load_pulse` that arrives when 80 words are already loaded in the current line writes nothing and sets `load_ovf`. `new_line` or `new_page` clears `load_ovf`.
- R9: Bit 15 of a stored word never reaches `disp_word`. Loaded words with bit 15 set appear on the display with only their low 15 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| new_word | input | 1 | Advance to the next character of the shifting row |
| new_line | input | 1 | End of row: swap bank roles, clear indices |
| new_page | input | 1 | Start of frame: bank select to 0, clear indices |
| load_pulse | input | 1 | Write `load_word` into the loading bank |
| load_word | input | 16 | Word from frame memory |
| test_manual | input | 1 | Manual self-test request |
| test_soft | input | 1 | Software self-test request |
| disp_loopback | input | 15 | Word returned by the display for checking |
| disp_word | output | 15 | Character word sent to the display |
| selftest_err | output | 1 | Sticky self-test mismatch flag |
| load_ovf | output | 1 | More than 80 loads arrived in one line |

## Verification
The bench first fills a row with exactly 80 loads while no character strobes occur. It then reads that row back with more than 80 character strobes while the other bank fills at the same time. This run separates correct bank steering from writes that land in the shifting row, and it exposes a character index that wraps instead of saturating. A burst of 83 loads separates a load index that clamps from one that overwrites or wraps. Strobes that coincide (line with word and load, page with line) check the priority order. A long random mix of all strobes catches state that slowly drifts away from the model. Test mode is entered through each of its two inputs in turn. Loopback faults are injected and then removed, which separates a sticky flag from a level-following one, and a clear-on-exit flag from one that is never cleared.

// File: rtl/lbuf_pkg.sv
// Package: shared names for the alternating row buffer.
// Assumes: two banks exactly; bank identity fits in one bit.
package lbuf_pkg;
    typedef enum logic {
        BANK_A = 1'b0,
        BANK_B = 1'b1
    } bank_e;
endpackage

// File: rtl/lbuf_seq.sv
// Module: lbuf_seq
// Sequences a line: character index, load index, bank select and overflow.
// Assumes: strobes are single-cycle pulses. new_page outranks new_line,
// and new_line outranks new_word and load_pulse in the same cycle.
module lbuf_seq #(
    parameter int ROW_LEN = 80,
    localparam int CNT_W  = $clog2(ROW_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               new_word,
    input  logic               new_line,
    input  logic               new_page,
    input  logic               load_pulse,
    output lbuf_pkg::bank_e    bank_sel,
    output logic [CNT_W-1:0]   word_idx,
    output logic [CNT_W-1:0]   load_idx,
    output logic               wr_en,
    output logic               ovf
);
    import lbuf_pkg::*;

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ROW_LEN - 1);
    localparam logic [CNT_W-1:0] FULL_IDX = CNT_W'(ROW_LEN);

    logic row_break;
    logic row_full;

    // Purpose: either strobe that restarts a row.
    assign row_break = new_line | new_page;
    // Purpose: loading bank has taken a full row.
    assign row_full  = (load_idx == FULL_IDX);
    // Purpose: a load that is allowed to write.
    assign wr_en     = load_pulse & ~row_break & ~row_full;

    // Purpose: bank select, page clears it and line inverts it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_sel <= BANK_A;
        end else if (new_page) begin
            bank_sel <= BANK_A;
        end else if (new_line) begin
            bank_sel <= (bank_sel == BANK_A) ? BANK_B : BANK_A;
        end
    end

    // Purpose: character index, saturating at the last column.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_idx <= '0;
        end else if (row_break) begin
            word_idx <= '0;
        end else if (new_word && (word_idx != LAST_IDX)) begin
            word_idx <= word_idx + 1'b1;
        end
    end

    // Purpose: load index, stops at a full row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_idx <= '0;
        end else if (row_break) begin
            load_idx <= '0;
        end else if (wr_en) begin
            load_idx <= load_idx + 1'b1;
        end
    end

    // Purpose: overflow flag for loads arriving at a full row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf <= 1'b0;
        end else if (row_break) begin
            ovf <= 1'b0;
        end else if (load_pulse && row_full) begin
            ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/lbuf_bank.sv
// Module: lbuf_bank
// One row register: one synchronous write port, one combinational read port.
// Assumes: indices stay below ROW_LEN (the sequencer guarantees this).
module lbuf_bank #(
    parameter int ROW_LEN = 80,
    parameter int WORD_W  = 16,
    localparam int CNT_W  = $clog2(ROW_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [CNT_W-1:0]   wr_idx,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic [CNT_W-1:0]   rd_idx,
    output logic [WORD_W-1:0]  rd_data
);
    logic [WORD_W-1:0] cells [ROW_LEN];

    // Purpose: store a word, clear the whole row on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ROW_LEN; i++) begin
                cells[i] <= '0;
            end
        end else if (wr_en) begin
            cells[wr_idx] <= wr_data;
        end
    end

    // Purpose: present the word at the read index.
    assign rd_data = cells[rd_idx];
endmodule

// File: rtl/lbuf_selftest.sv
// Module: lbuf_selftest
// Builds the counter test pattern and checks the display loopback against it.
// Assumes: the loopback returns the word shown in the same cycle.
module lbuf_selftest #(
    parameter int ROW_LEN = 80,
    parameter int OUT_W   = 15,
    localparam int CNT_W  = $clog2(ROW_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               test_on,
    input  logic [CNT_W-1:0]   word_idx,
    input  logic [OUT_W-1:0]   loopback,
    output logic [OUT_W-1:0]   pattern,
    output logic               err
);
    // Purpose: repeat the character index across the output bits.
    for (genvar i = 0; i < OUT_W; i++) begin : g_pat
        assign pattern[i] = word_idx[i % CNT_W];
    end

    // Purpose: sticky mismatch flag, cleared when test mode ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err <= 1'b0;
        end else if (!test_on) begin
            err <= 1'b0;
        end else if (loopback != pattern) begin
            err <= 1'b1;
        end
    end
endmodule

// File: rtl/row_pingpong_buffer.sv
// Module: row_pingpong_buffer
// Two row registers in alternation: one shifts to the display while the other
// loads from frame memory, with a counter-based self-test path.
// Assumes: single clock domain; strobes already synchronised and one cycle long.
module row_pingpong_buffer #(
    parameter int ROW_LEN = 80,
    parameter int WORD_W  = 16,
    parameter int OUT_W   = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              new_word,
    input  logic              new_line,
    input  logic              new_page,
    input  logic              load_pulse,
    input  logic [WORD_W-1:0] load_word,
    input  logic              test_manual,
    input  logic              test_soft,
    input  logic [OUT_W-1:0]  disp_loopback,
    output logic [OUT_W-1:0]  disp_word,
    output logic              selftest_err,
    output logic              load_ovf
);
    import lbuf_pkg::*;

    localparam int CNT_W   = $clog2(ROW_LEN + 1);
    localparam int N_BANKS = 2;

    bank_e             bank_sel;
    logic [CNT_W-1:0]  word_idx;
    logic [CNT_W-1:0]  load_idx;
    logic              wr_en;
    logic              test_on;
    logic [OUT_W-1:0]  pattern;
    logic [WORD_W-1:0] bank_rd [N_BANKS];
    logic [WORD_W-1:0] shift_word;

    // Purpose: either test source enables test mode.
    assign test_on = test_manual | test_soft;

    lbuf_seq #(.ROW_LEN(ROW_LEN)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .new_word   (new_word),
        .new_line   (new_line),
        .new_page   (new_page),
        .load_pulse (load_pulse),
        .bank_sel   (bank_sel),
        .word_idx   (word_idx),
        .load_idx   (load_idx),
        .wr_en      (wr_en),
        .ovf        (load_ovf)
    );

    // Purpose: one row register per bank; only the unselected bank is written.
    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        lbuf_bank #(.ROW_LEN(ROW_LEN), .WORD_W(WORD_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en && (bank_sel != bank_e'(b))),
            .wr_idx  (load_idx),
            .wr_data (load_word),
            .rd_idx  (word_idx),
            .rd_data (bank_rd[b])
        );
    end

    // Purpose: pick the shifting bank's word.
    assign shift_word = bank_rd[bank_sel];

    lbuf_selftest #(.ROW_LEN(ROW_LEN), .OUT_W(OUT_W)) u_test (
        .clk      (clk),
        .rst_n    (rst_n),
        .test_on  (test_on),
        .word_idx (word_idx),
        .loopback (disp_loopback),
        .pattern  (pattern),
        .err      (selftest_err)
    );

    // Purpose: display stream, test pattern or stored row truncated to OUT_W.
    assign disp_word = test_on ? pattern : shift_word[OUT_W-1:0];
endmodule

// File: rtl/lbuf_checker.sv
// Module: lbuf_checker
// Temporal checks on the row buffer, attached to the top module by bind.
module lbuf_checker #(
    parameter int ROW_LEN = 80,
    localparam int CNT_W  = $clog2(ROW_LEN + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             new_word,
    input logic             new_line,
    input logic             new_page,
    input logic             load_pulse,
    input logic             test_on,
    input logic             bank_sel,
    input logic [CNT_W-1:0] word_idx,
    input logic [CNT_W-1:0] load_idx,
    input logic             selftest_err,
    input logic             load_ovf
);
    assert_word_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (new_word && !new_line && !new_page && word_idx < CNT_W'(ROW_LEN - 1))
        |=> word_idx == $past(word_idx) + 1'b1);

    assert_word_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (new_word && !new_line && !new_page && word_idx == CNT_W'(ROW_LEN - 1))
        |=> word_idx == CNT_W'(ROW_LEN - 1));

    assert_line_swap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (new_line && !new_page) |=> (bank_sel != $past(bank_sel)) && word_idx == '0 && load_idx == '0);

    assert_page_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        new_page |=> (bank_sel == 1'b0) && word_idx == '0 && load_idx == '0);

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (selftest_err && test_on) |=> selftest_err);

    assert_err_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !test_on |=> !selftest_err);

    assert_load_clamp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (load_pulse && load_idx == CNT_W'(ROW_LEN) && !new_line && !new_page)
        |=> load_ovf && load_idx == CNT_W'(ROW_LEN));
endmodule

bind row_pingpong_buffer lbuf_checker #(.ROW_LEN(ROW_LEN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .new_word     (new_word),
    .new_line     (new_line),
    .new_page     (new_page),
    .load_pulse   (load_pulse),
    .test_on      (test_on),
    .bank_sel     (bank_sel),
    .word_idx     (word_idx),
    .load_idx     (load_idx),
    .selftest_err (selftest_err),
    .load_ovf     (load_ovf)
);

// File: tb/row_pingpong_buffer_tb.sv
module row_pingpong_buffer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ROW = 80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nw = 0, nl = 0, np = 0, ld = 0;
    logic [15:0] ldw = '0;
    logic        tman = 0, tsoft = 0;
    logic [14:0] fault = '0;
    logic [14:0] disp_word;
    logic [14:0] loopback;
    logic        selftest_err, load_ovf;

    int    n_chk = 0, n_bad = 0;
    bit    done = 0;
    string tag = "R1";

    assign loopback = disp_word ^ fault;

    always #(CLK_PERIOD/2) clk = ~clk;

    row_pingpong_buffer u_dut (
        .clk(clk), .rst_n(rst_n), .new_word(nw), .new_line(nl), .new_page(np),
        .load_pulse(ld), .load_word(ldw), .test_manual(tman), .test_soft(tsoft),
        .disp_loopback(loopback), .disp_word(disp_word),
        .selftest_err(selftest_err), .load_ovf(load_ovf)
    );

    // Behavioural reference model
    logic [15:0] m_mem [2][ROW];
    int m_sel, m_widx, m_lidx;
    bit m_ovf, m_err;

    function automatic logic [14:0] pat_of(int idx);
        logic [14:0] p;
        for (int i = 0; i < 15; i++) p[i] = 1'((idx >> (i % 7)) & 1);
        return p;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < 2; b++) for (int i = 0; i < ROW; i++) m_mem[b][i] = '0;
            m_sel = 0; m_widx = 0; m_lidx = 0; m_ovf = 0; m_err = 0;
        end else begin
            m_err = (tman | tsoft) ? (m_err | (fault != '0)) : 1'b0;
            if (np) begin
                m_sel = 0; m_widx = 0; m_lidx = 0; m_ovf = 0;
            end else if (nl) begin
                m_sel = 1 - m_sel; m_widx = 0; m_lidx = 0; m_ovf = 0;
            end else begin
                if (nw && m_widx < ROW - 1) m_widx++;
                if (ld) begin
                    if (m_lidx < ROW) begin
                        m_mem[1 - m_sel][m_lidx] = ldw;
                        m_lidx++;
                    end else m_ovf = 1;
                end
            end
        end
    end

    task automatic check(string t, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", t, act, exp, $time);
        end
    endtask

    // Compare on every falling edge, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            logic [14:0] e_disp;
            e_disp = (tman | tsoft) ? pat_of(m_widx) : m_mem[m_sel][m_widx][14:0];
            check({tag, " disp"}, {1'b0, disp_word}, {1'b0, e_disp});
            check({tag, " err R7"}, {15'b0, selftest_err}, {15'b0, m_err});
            check({tag, " ovf R8"}, {15'b0, load_ovf}, {15'b0, m_ovf});
        end
    end

    task automatic step(bit w, bit l, bit p, bit d, logic [15:0] data);
        nw = w; nl = l; np = p; ld = d; ldw = data;
        @(posedge clk); #1;
        nw = 0; nl = 0; np = 0; ld = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        // R1: reset state
        tag = "R1";
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 disp", {1'b0, disp_word}, 16'h0);
        check("R1 ovf", {15'b0, load_ovf}, 16'h0);
        @(posedge clk); #1;

        // R2: fill the loading bank with exactly a full row
        tag = "R2";
        for (int i = 0; i < ROW; i++) step(0, 0, 0, 1, 16'($urandom));
        step(0, 1, 0, 0, '0);

        // R3: read back beyond the row end while the other bank fills
        tag = "R3";
        for (int i = 0; i < ROW + 6; i++) step(1, 0, 0, (i < ROW), 16'($urandom));

        // R9: words with bit 15 set
        tag = "R9";
        step(0, 1, 0, 0, '0);
        for (int i = 0; i < ROW; i++) step(0, 0, 0, 1, 16'h8000 | 16'(i * 517));
        step(0, 1, 0, 0, '0);
        for (int i = 0; i < ROW; i++) step(1, 0, 0, 0, '0);

        // R4: line strobe coincident with word and load
        tag = "R4";
        step(1, 1, 0, 1, 16'h1234);
        for (int i = 0; i < 5; i++) step(1, 0, 0, 1, 16'($urandom));

        // R8: overflow on loads past a full row, cleared by the line strobe
        tag = "R8";
        step(0, 1, 0, 0, '0);
        for (int i = 0; i < ROW + 3; i++) step(0, 0, 0, 1, 16'hA000 + 16'(i));
        step(0, 0, 0, 0, '0);
        step(0, 1, 0, 0, '0);
        for (int i = 0; i < ROW; i++) step(1, 0, 0, 0, '0);

        // R5: page strobe outranks line, even with bank B selected
        tag = "R5";
        step(0, 1, 0, 0, '0);
        step(1, 0, 0, 1, 16'h5555);
        step(1, 1, 1, 1, 16'h6666);
        step(1, 0, 0, 0, '0);

        // random mix of every strobe
        tag = "R4";
        for (int i = 0; i < 3000; i++)
            step(($urandom % 2) == 0, ($urandom % 90) == 0, ($urandom % 400) == 0,
                 ($urandom % 3) != 0, 16'($urandom));

        // R6: test mode from each input
        tag = "R6";
        tman = 1;
        step(0, 1, 0, 0, '0);
        for (int i = 0; i < ROW + 2; i++) step(1, 0, 0, 0, '0);
        tman = 0; step(0, 0, 0, 0, '0);
        tsoft = 1;
        step(0, 0, 1, 0, '0);
        for (int i = 0; i < 20; i++) step(1, 0, 0, 0, '0);

        // R7: injected loopback fault, then removed; flag sticks until exit
        tag = "R7";
        fault = 15'h0004;
        step(1, 0, 0, 0, '0);
        fault = '0;
        for (int i = 0; i < 5; i++) step(1, 0, 0, 0, '0);
        tsoft = 0;
        step(0, 0, 0, 0, '0);
        step(0, 0, 0, 0, '0);
        tman = 1; tsoft = 1;
        for (int i = 0; i < 4; i++) step(1, 0, 0, 0, '0);
        tman = 0; tsoft = 0;
        step(0, 0, 0, 0, '0);

        @(negedge clk);
        finish_run();
    end
endmodule